// File: doc/BRIEF.md
# Parallel Flash Command Controller

This block models a byte-wide parallel flash device behind an active-low chip-enable, output-enable and write-enable bus. Reads return the stored byte at the addressed location. Writes do not reach the storage directly. Each bus write goes to a command decoder. Only a complete unlock sequence can start a byte program or a chip erase, and both are then timed inside the block by a cycle counter. While an operation runs, a read returns a poll byte in place of the stored data, so the host can tell when the operation has finished.

The address space is 19 bits. Addresses below 0x4000 form a 16 KB boot region, which a one-way lock can freeze against both program and erase. Real storage is kept small. Each region (boot and main) holds 2^CELL_AW byte cells, selected by the low CELL_AW address bits, so higher addresses alias onto those cells. Programming can only clear bits. Erasing sets bits back to 1. The bus inputs are sampled on the rising edge of `clk`. A synchronous reset clears the command decoder and the operation timer but leaves the storage and the lock untouched.

Top module: `flash_top`

## Requirements
- R1: After power-up every cell reads 0xFF and the boot lock is off. With ce_n=0, oe_n=0 and we_n=1, data_oe is 1 and, when no operation is running, data_out shows the byte of the addressed cell in the same cycle.
- R2: data_oe is 0 whenever ce_n or oe_n is 1.
- R3: A write cycle lasts while ce_n and we_n are both 0. Its address is the value sampled in the first cycle of that overlap, and its data is the value sampled in the last cycle of that overlap.
- R4: The writes 0xAA to 0x5555, 0x55 to 0x2AAA and 0xA0 to 0x5555, followed by a fourth write of D to address A, program A. The write starts an operation of PROG_CYCLES cycles, and at its end the cell holds its old value AND D.
- R5: While an operation runs, every read returns {~D[7], 7'b0} during a program and 0x00 during an erase. After the operation ends, reads return the stored data again.
- R6: A write that does not match the next expected step (address or data) returns the decoder to idle and changes no cell. A following write must start the sequence again from 0xAA to 0x5555.
- R7: The six writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA and 0x10@0x5555 start a chip erase. The erase walks one cell per cycle and sets every cell it may touch to 0xFF. It stays busy for max(ERASE_CYCLES, cell count) cycles.
- R8: Bus writes that complete while an operation is running are ignored.
- R9: The writes 0xAA@0x5555, 0x55@0x2AAA and 0x40@0x5555, followed by any write, set the boot lock. Once set, the lock never clears. A program aimed at a boot address starts no operation and changes nothing, and an erase leaves every boot cell unchanged.
- R10: rst_n=0 returns the decoder and timer to idle and leaves every cell and the lock as they were.
- R11: An address below 0x4000 selects boot cell addr[CELL_AW-1:0]. Any other address selects main cell addr[CELL_AW-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset of decoder and timer |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| data_in | input | 8 | Write data |
| data_out | output | 8 | Read data or poll byte |
| data_oe | output | 1 | Output drive enable for the data pins |

## Verification
A decoder that sits in the wrong state shows up at the ports within one command sequence. Either a program that should take effect leaves the cell unchanged, or a stray sequence changes a cell, and a read after the expected PROG_CYCLES window exposes the difference. A timer that stops early or late makes the poll byte appear or disappear on the wrong read, one cycle after the final write. A lock bit or erase walker that misbehaves leaves a boot or main cell with the wrong value after an erase. For that reason, every cell is read back after each program sweep and each erase.

// File: rtl/flash_pkg.sv
package flash_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE, CMD_U1, CMD_U2, CMD_PROG, CMD_ER1, CMD_ER2, CMD_ER3, CMD_LOCK
  } cmd_e;

  typedef enum logic [1:0] {OP_IDLE, OP_PROG, OP_ERASE} op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       busy;
    logic       progWr;
    logic       eraseEn;
    logic       lockSet;
    logic [7:0] progData;
    logic [7:0] pollByte;
  } strobe_t;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] CODE_PROG  = 8'hA0;
  localparam logic [7:0] CODE_ERASE = 8'h80;
  localparam logic [7:0] CODE_LOCK  = 8'h40;
  localparam logic [7:0] CODE_CONF  = 8'h10;
  localparam int unsigned SEQ_ADDR_A = 32'h5555;
  localparam int unsigned SEQ_ADDR_B = 32'h2AAA;

endpackage

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int BOOT_AW      = 14,
  parameter int CELL_AW      = 4,
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce_n,
  input  logic                we_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          dataIn,
  input  logic                bootLock,
  output strobe_t             strb,
  output logic [CELL_AW:0]    cellIdx
);

  localparam int IDX_W     = CELL_AW + 1;
  localparam int NCELLS    = 2 ** IDX_W;
  localparam int ERASE_LEN = (ERASE_CYCLES > NCELLS) ? ERASE_CYCLES : NCELLS;
  localparam int CNT_MAX   = (PROG_CYCLES > ERASE_LEN) ? PROG_CYCLES : ERASE_LEN;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  logic              wrAct, prevAct, wrStart, wrEnd;
  logic [ADDR_W-1:0] addrLat;
  logic [7:0]        dataLat;
  cmd_e              cmd, cmdNext;
  op_e               op;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  opIdx, latIdx, eraseIdx;
  logic [7:0]        opData;
  logic              isA, isB, latIsBoot, startProg, startErase, lockReq;

  assign wrAct   = !ce_n && !we_n;
  assign wrStart = wrAct && !prevAct;
  assign wrEnd   = !wrAct && prevAct;

  assign isA       = (addrLat == ADDR_W'(SEQ_ADDR_A));
  assign isB       = (addrLat == ADDR_W'(SEQ_ADDR_B));
  assign latIsBoot = (addrLat[ADDR_W-1:BOOT_AW] == '0);
  assign latIdx    = {!latIsBoot, addrLat[CELL_AW-1:0]};

  // bus cycle capture: address at start of overlap, data while it lasts
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevAct <= 1'b0;
      addrLat <= '0;
      dataLat <= '0;
    end else begin
      prevAct <= wrAct;
      if (wrStart) addrLat <= addr;
      if (wrAct)   dataLat <= dataIn;
    end
  end

  // command decoder
  always_comb begin
    cmdNext    = cmd;
    startProg  = 1'b0;
    startErase = 1'b0;
    lockReq    = 1'b0;
    if (wrEnd && op == OP_IDLE) begin
      cmdNext = CMD_IDLE;
      unique case (cmd)
        CMD_IDLE: if (isA && dataLat == KEY_FIRST)  cmdNext = CMD_U1;
        CMD_U1:   if (isB && dataLat == KEY_SECOND) cmdNext = CMD_U2;
        CMD_U2: begin
          if (isA) begin
            if (dataLat == CODE_PROG)  cmdNext = CMD_PROG;
            if (dataLat == CODE_ERASE) cmdNext = CMD_ER1;
            if (dataLat == CODE_LOCK)  cmdNext = CMD_LOCK;
          end
        end
        CMD_PROG: startProg = !(latIsBoot && bootLock);
        CMD_ER1:  if (isA && dataLat == KEY_FIRST)  cmdNext = CMD_ER2;
        CMD_ER2:  if (isB && dataLat == KEY_SECOND) cmdNext = CMD_ER3;
        CMD_ER3:  startErase = isA && (dataLat == CODE_CONF);
        CMD_LOCK: lockReq = 1'b1;
        default:  cmdNext = CMD_IDLE;
      endcase
    end
  end

  // operation timer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd    <= CMD_IDLE;
      op     <= OP_IDLE;
      cnt    <= '0;
      opIdx  <= '0;
      opData <= '0;
    end else begin
      cmd <= cmdNext;
      unique case (op)
        OP_IDLE: begin
          cnt <= '0;
          if (startProg) begin
            op     <= OP_PROG;
            opIdx  <= latIdx;
            opData <= dataLat;
          end else if (startErase) begin
            op <= OP_ERASE;
          end
        end
        OP_PROG:
          if (cnt == CNT_W'(PROG_CYCLES - 1)) op <= OP_IDLE;
          else cnt <= cnt + 1'b1;
        OP_ERASE:
          if (cnt == CNT_W'(ERASE_LEN - 1)) op <= OP_IDLE;
          else cnt <= cnt + 1'b1;
        default: op <= OP_IDLE;
      endcase
    end
  end

  assign eraseIdx = cnt[IDX_W-1:0];

  always_comb begin
    strb.busy     = (op != OP_IDLE);
    strb.progWr   = (op == OP_PROG) && (cnt == CNT_W'(PROG_CYCLES - 1));
    strb.eraseEn  = (op == OP_ERASE) && (cnt < CNT_W'(NCELLS))
                    && !(!eraseIdx[IDX_W-1] && bootLock);
    strb.lockSet  = lockReq;
    strb.progData = opData;
    strb.pollByte = (op == OP_PROG) ? {~opData[7], 7'b0} : 8'h00;
    cellIdx       = (op == OP_ERASE) ? eraseIdx : opIdx;
  end

endmodule

// File: rtl/flash_dpath.sv
module flash_dpath
  import flash_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int BOOT_AW = 14,
  parameter int CELL_AW = 4
) (
  input  logic              clk,
  input  strobe_t           strb,
  input  logic [CELL_AW:0]  cellIdx,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  output logic              bootLock,
  output logic [7:0]        dataOut,
  output logic              dataOe
);

  localparam int IDX_W  = CELL_AW + 1;
  localparam int NCELLS = 2 ** IDX_W;

  // storage and lock hold their power-up value; reset does not touch them
  logic [NCELLS-1:0][7:0] cells = '1;
  logic                   lockQ = 1'b0;
  logic [IDX_W-1:0]       rdIdx;

  always_ff @(posedge clk) begin
    if (strb.lockSet) lockQ <= 1'b1;
    for (int i = 0; i < NCELLS; i++) begin
      if (cellIdx == IDX_W'(i)) begin
        if (strb.eraseEn)     cells[i] <= 8'hFF;
        else if (strb.progWr) cells[i] <= cells[i] & strb.progData;
      end
    end
  end

  assign bootLock = lockQ;
  assign rdIdx    = {addr[ADDR_W-1:BOOT_AW] != '0, addr[CELL_AW-1:0]};
  assign dataOut  = strb.busy ? strb.pollByte : cells[rdIdx];
  assign dataOe   = !ce_n && !oe_n && we_n;

endmodule

// File: rtl/flash_top.sv
module flash_top #(
  parameter int ADDR_W       = 19,
  parameter int BOOT_AW      = 14,
  parameter int CELL_AW      = 4,
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data_in,
  output logic [7:0]        data_out,
  output logic              data_oe
);

  flash_pkg::strobe_t strb;
  logic [CELL_AW:0]   cellIdx;
  logic               bootLock;

  flash_ctrl #(
    .ADDR_W(ADDR_W), .BOOT_AW(BOOT_AW), .CELL_AW(CELL_AW),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .dataIn(data_in), .bootLock(bootLock), .strb(strb), .cellIdx(cellIdx)
  );

  flash_dpath #(
    .ADDR_W(ADDR_W), .BOOT_AW(BOOT_AW), .CELL_AW(CELL_AW)
  ) u_dpath (
    .clk(clk), .strb(strb), .cellIdx(cellIdx), .addr(addr), .ce_n(ce_n),
    .oe_n(oe_n), .we_n(we_n), .bootLock(bootLock), .dataOut(data_out),
    .dataOe(data_oe)
  );

endmodule

// File: rtl/flash_chk.sv
module flash_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             progWr,
  input logic             eraseEn,
  input logic             lockSet,
  input logic             bootLock,
  input logic [IDX_W-1:0] cellIdx,
  input logic             dataOe,
  input logic [7:0]       dataOut
);

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bootLock |=> bootLock);

  // R9
  boot_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (progWr && bootLock) |-> cellIdx[IDX_W-1]);

  // R7
  boot_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eraseEn && bootLock) |-> cellIdx[IDX_W-1]);

  // R5
  poll_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dataOe) |-> (dataOut[6:0] == 7'd0));

  // R8
  lock_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lockSet |-> !busy);

  // R10
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !busy);

endmodule

bind flash_top flash_chk #(.IDX_W(CELL_AW + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(strb.busy), .progWr(strb.progWr),
  .eraseEn(strb.eraseEn), .lockSet(strb.lockSet), .bootLock(bootLock),
  .cellIdx(cellIdx), .dataOe(data_oe), .dataOut(data_out)
);

// File: tb/sim_flash_top.sv
module sim_flash_top;

  localparam int AW = 19;
  localparam int CAW = 3;
  localparam int NC = 16;
  localparam int PROG = 6;
  localparam int ERASE = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic doe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] mdl [NC];

  always #10 clk = ~clk;

  flash_top #(.ADDR_W(AW), .BOOT_AW(14), .CELL_AW(CAW),
              .PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .data_in(din), .data_out(dout), .data_oe(doe));

  function automatic int idxOf(logic [AW-1:0] a);
    return ((a >= 19'h4000) ? 8 : 0) + int'(a[2:0]);
  endfunction

  function automatic logic [AW-1:0] addrOf(int i);
    return (i >= 8) ? AW'(32'h4000 + i - 8) : AW'(i);
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 0; we_n = 0;
    @(negedge clk); ce_n = 1; we_n = 1;
  endtask

  task automatic busRead(logic [AW-1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk); addr = a; ce_n = 0; oe_n = 0; we_n = 1;
    #1; d = dout; oe = doe;
    #1; ce_n = 1; oe_n = 1;
  endtask

  task automatic unlock(logic [7:0] code);
    busWrite(19'h5555, 8'hAA);
    busWrite(19'h2AAA, 8'h55);
    busWrite(19'h5555, code);
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readAll(string tag);
    logic [7:0] d; logic oe;
    for (int i = 0; i < NC; i++) begin
      busRead(addrOf(i), d, oe);
      check(tag, d, mdl[i]);
    end
  endtask

  task automatic doErase();
    logic [7:0] d; logic oe;
    unlock(8'h80);
    busWrite(19'h5555, 8'hAA);
    busWrite(19'h2AAA, 8'h55);
    busWrite(19'h5555, 8'h10);
    busRead(19'h4001, d, oe);
    check("R5 erase poll", d, 8'h00);
  endtask

  initial begin
    logic [7:0] d; logic oe;
    for (int i = 0; i < NC; i++) mdl[i] = 8'hFF;
    waitCycles(3);
    rst_n = 1;

    // R1 power-up state and read path
    busRead(19'h00000, d, oe);
    check("R1 oe on read", {7'b0, oe}, 8'h01);
    readAll("R1 power-up FF");

    // R2 output enable gating
    @(negedge clk); ce_n = 1; oe_n = 0; #1; check("R2 ce high", {7'b0, doe}, 8'h00);
    ce_n = 0; oe_n = 1; #1; check("R2 oe high", {7'b0, doe}, 8'h00);
    ce_n = 1; oe_n = 1;

    // R4 / R5 program sweep, two passes to see the AND
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < NC; i++) begin
        logic [7:0] v;
        v = (pass == 0) ? 8'((i * 53 + 60) & 255) : 8'(~(i * 29) & 255);
        unlock(8'hA0);
        busWrite(addrOf(i), v);
        busRead(19'h7FFFF, d, oe);
        check("R5 program poll", d, {~v[7], 7'b0});
        waitCycles(PROG + 1);
        mdl[i] = mdl[i] & v;
        busRead(addrOf(i), d, oe);
        check("R4 programmed value", d, mdl[i]);
      end
    end

    // R11 aliasing of higher address bits
    for (int i = 0; i < NC; i++) begin
      busRead(addrOf(i) | 19'h38, d, oe);
      check("R11 alias", d, mdl[i]);
    end

    // R6 out-of-sequence writes
    busWrite(19'h5555, 8'hAA);
    busWrite(19'h2AAA, 8'h33);
    busWrite(19'h5555, 8'hA0);
    busWrite(19'h4006, 8'h00);
    waitCycles(PROG + 1);
    busRead(19'h4006, d, oe);
    check("R6 wrong data", d, mdl[14]);
    busWrite(19'h5555, 8'hAA);
    busWrite(19'h2AAB, 8'h55);
    busWrite(19'h5555, 8'hA0);
    busWrite(19'h0004, 8'h00);
    waitCycles(PROG + 1);
    busRead(19'h0004, d, oe);
    check("R6 wrong address", d, mdl[4]);

    // R7 erase, with R8 writes during busy
    doErase();
    unlock(8'hA0);
    busWrite(19'h4000, 8'h00);
    waitCycles(ERASE);
    for (int i = 0; i < NC; i++) mdl[i] = 8'hFF;
    readAll("R7 erased / R8 busy writes ignored");
    busWrite(19'h4000, 8'h00);
    waitCycles(PROG + 1);
    busRead(19'h4000, d, oe);
    check("R8 decoder idle after erase", d, 8'hFF);

    // R3 address from first overlap cycle, data from last
    unlock(8'hA0);
    @(negedge clk); addr = 19'h4003; din = 8'h11; ce_n = 0; we_n = 0;
    @(negedge clk); addr = 19'h4005; din = 8'hF0;
    @(negedge clk); ce_n = 1; we_n = 1;
    waitCycles(PROG + 1);
    mdl[11] = 8'hF0;
    busRead(19'h4003, d, oe); check("R3 data last cycle", d, 8'hF0);
    busRead(19'h4005, d, oe); check("R3 address first cycle", d, 8'hFF);
    unlock(8'hA0);
    @(negedge clk); addr = 19'h4007; din = 8'h00; ce_n = 0;
    @(negedge clk); addr = 19'h4002; din = 8'h3C; we_n = 0;
    @(negedge clk); ce_n = 1; we_n = 1;
    waitCycles(PROG + 1);
    mdl[10] = 8'h3C;
    busRead(19'h4002, d, oe); check("R3 later falling edge", d, 8'h3C);
    busRead(19'h4007, d, oe); check("R3 early address unused", d, 8'hFF);

    // boot cell 1 programmed before lock
    unlock(8'hA0); busWrite(19'h0001, 8'h5A); waitCycles(PROG + 1);
    mdl[1] = 8'h5A;

    // R10 reset mid-sequence
    busWrite(19'h5555, 8'hAA);
    busWrite(19'h2AAA, 8'h55);
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    busWrite(19'h5555, 8'hA0);
    busWrite(19'h0001, 8'h00);
    waitCycles(PROG + 1);
    readAll("R10 reset keeps array");

    // R9 lock
    unlock(8'h40); busWrite(19'h0000, 8'h00);
    unlock(8'hA0); busWrite(19'h0001, 8'h00);
    busRead(19'h0001, d, oe);
    check("R9 boot program not started", d, 8'h5A);
    waitCycles(PROG + 1);
    doErase(); waitCycles(ERASE);
    for (int i = 8; i < NC; i++) mdl[i] = 8'hFF;
    readAll("R9 erase skips boot");
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    unlock(8'hA0); busWrite(19'h0002, 8'h00); waitCycles(PROG + 1);
    busRead(19'h0002, d, oe);
    check("R9 R10 lock survives reset", d, mdl[2]);
    unlock(8'hA0); busWrite(19'h4004, 8'h81); waitCycles(PROG + 1);
    mdl[12] = 8'h81;
    busRead(19'h4004, d, oe);
    check("R4 main program after lock", d, 8'h81);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule